// File: doc/BRIEF.md
# Banked Vector Scratchpad Alignment Datapath

This block is the operand datapath of a vector engine. Its local memory is split into byte-wide banks, each byte stored with a ninth bit that serves as a condition flag. Consecutive bytes, and so consecutive vector elements, fall into consecutive banks. A vector instruction names two source operands and one destination by byte pointer. Each pointer may start in any bank.

While the instruction runs, the block processes one group of up to four elements per cycle. For each operand it works out a separate row address for every bank. It rotates both source rows so that the first element of the group sits in lane 0. It widens the source elements to 32 bits with sign or zero extension. A placeholder ALU then either passes operand A through or adds A and B. The block narrows the results to the destination size and rotates them back onto the destination's starting bank. The vector length limits the byte write enables. A plain byte port lets the surrounding logic load and inspect the memory while the engine is idle.

Top module: `vspad_align`

## Requirements
- R1: Byte address x is stored in bank x mod 16 at row x div 16. A write through the host port (`hst_we_i`, data bit 8 = flag) is returned unchanged by the combinational host read at the same address.
- R2: Source and destination pointers at any byte offset are processed correctly. A group that straddles a row boundary takes the next row in the banks below the start offset.
- R3: Element i of the result is computed from element i of each source, where source element i starts at byte pointer + i*source size.
- R4: Source size (0 = 8 bit, 1 = 16 bit, 2 = 32 bit) is widened to 32 bits by zero extension when `src_signed_i` = 0 and by sign extension when it is 1.
- R5: Results are narrowed to the destination size (same encoding) by keeping the low bytes, and element i is stored little-endian at destination pointer + i*destination size.
- R6: Bytes outside the destination range are left unchanged, including the other bytes of the first and last destination rows.
- R7: Exactly `vlen_i` elements are written. A final partial group writes only its valid bytes, and `vlen_i` = 0 writes nothing.
- R8: With `op_i` = 1 (add), every byte of a destination element gets the flag equal to bit 8*dst_bytes of the 33-bit unsigned sum of the widened operands. With `op_i` = 0 (pass), the result is operand A, and the flag is the OR of the flags of A's element bytes.
- R9: After `start_i` is sampled while idle, `busy_o` is high for max(1, ceil(vlen/4)) cycles. `done_o` is then high for exactly one cycle, the cycle after the last group.
- R10: After reset, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an instruction (sampled when idle) |
| op_i | input | 1 | 0 = pass A, 1 = add A+B |
| src_sz_i | input | 2 | Source element size code |
| dst_sz_i | input | 2 | Destination element size code |
| src_signed_i | input | 1 | Sign-extend sources |
| ptr_a_i | input | 8 | Byte pointer of source A |
| ptr_b_i | input | 8 | Byte pointer of source B |
| ptr_d_i | input | 8 | Byte pointer of destination |
| vlen_i | input | 8 | Number of elements |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hst_we_i | input | 1 | Host byte write (idle only) |
| hst_addr_i | input | 8 | Host byte address |
| hst_wdata_i | input | 9 | Host write data, bit 8 = flag |
| hst_rdata_o | output | 9 | Host read data, bit 8 = flag |

## Verification
The whole memory is filled with a pseudo-random pattern with random flags, and after each instruction every byte is compared against a byte-array model. This catches stray writes as well as wrong results. Aligned pointers are tried against pointers at different offsets in each operand, which separates the rotation networks from the per-bank row selection. Byte-to-halfword and byte-to-word conversions are run unsigned and signed, and word-to-byte and halfword-to-byte narrowing is run too, so the extension and truncation paths are exercised. Vector lengths of 0, 5, 7 and 16 show the partial-group write masking and the busy cycle count.

// File: rtl/vspad_pkg.sv
package vspad_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  function automatic logic [1:0] norm_sz(input logic [1:0] sz);
    return (sz == 2'd3) ? 2'd2 : sz;
  endfunction
endpackage

// File: rtl/vspad_bank.sv
module vspad_bank #(
  parameter int ROWS = 16,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [8:0]    wdata_i,
  input  logic [RW-1:0] raddr_a_i,
  output logic [8:0]    rdata_a_o,
  input  logic [RW-1:0] raddr_b_i,
  output logic [8:0]    rdata_b_o,
  input  logic [RW-1:0] raddr_h_i,
  output logic [8:0]    rdata_h_o
);
  logic [8:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
  assign rdata_h_o = mem_q[raddr_h_i];
endmodule

// File: rtl/vspad_src_align.sv
module vspad_src_align #(
  parameter int NB   = 4,
  parameter int ROWS = 16,
  localparam int RB = NB * 4,
  localparam int OW = $clog2(RB),
  localparam int RW = $clog2(ROWS),
  localparam int AW = OW + RW
) (
  input  logic [AW-1:0]          base_i,
  input  logic [1:0]             sz_i,
  input  logic                   sgn_i,
  output logic [RB-1:0][RW-1:0]  row_o,
  input  logic [RB-1:0][8:0]     rd_i,
  output logic [NB-1:0][31:0]    lane_o,
  output logic [NB-1:0]          flag_o
);
  logic [OW-1:0] off;
  logic [RW-1:0] row;
  logic [RB-1:0][8:0] rot;

  assign off = base_i[OW-1:0];
  assign row = base_i[AW-1:OW];

  // banks below the start offset belong to the next row
  always_comb begin
    for (int j = 0; j < RB; j++)
      row_o[j] = row + ((OW'(j) < off) ? RW'(1) : RW'(0));
  end

  always_comb begin
    logic [OW-1:0] idx;
    for (int i = 0; i < RB; i++) begin
      idx    = OW'(i) + off;
      rot[i] = rd_i[idx];
    end
  end

  // widen to 32 bits
  always_comb begin
    for (int e = 0; e < NB; e++) begin
      case (sz_i)
        2'd0: begin
          lane_o[e] = {{24{sgn_i & rot[e][7]}}, rot[e][7:0]};
          flag_o[e] = rot[e][8];
        end
        2'd1: begin
          lane_o[e] = {{16{sgn_i & rot[2*e+1][7]}}, rot[2*e+1][7:0], rot[2*e][7:0]};
          flag_o[e] = rot[2*e][8] | rot[2*e+1][8];
        end
        default: begin
          lane_o[e] = {rot[4*e+3][7:0], rot[4*e+2][7:0], rot[4*e+1][7:0], rot[4*e][7:0]};
          flag_o[e] = rot[4*e][8] | rot[4*e+1][8] | rot[4*e+2][8] | rot[4*e+3][8];
        end
      endcase
    end
  end
endmodule

// File: rtl/vspad_dst_align.sv
module vspad_dst_align #(
  parameter int NB   = 4,
  parameter int ROWS = 16,
  localparam int RB  = NB * 4,
  localparam int OW  = $clog2(RB),
  localparam int RW  = $clog2(ROWS),
  localparam int AW  = OW + RW,
  localparam int NVW = $clog2(NB + 1)
) (
  input  logic                   en_i,
  input  logic [AW-1:0]          base_i,
  input  logic [1:0]             sz_i,
  input  logic [NVW-1:0]         nval_i,
  input  logic [NB-1:0][31:0]    lane_i,
  input  logic [NB-1:0]          flag_i,
  output logic [RB-1:0][RW-1:0]  row_o,
  output logic [RB-1:0][8:0]     wdata_o,
  output logic [RB-1:0]          we_o
);
  logic [OW-1:0] off;
  logic [RW-1:0] row;
  logic [RB-1:0][8:0] pk;
  logic [OW:0] nbytes;

  assign off    = base_i[OW-1:0];
  assign row    = base_i[AW-1:OW];
  assign nbytes = (OW+1)'(nval_i) << sz_i;

  // narrow: keep low bytes of each lane, packed from byte 0
  always_comb begin
    pk = '0;
    for (int e = 0; e < NB; e++) begin
      case (sz_i)
        2'd0: pk[e] = {flag_i[e], lane_i[e][7:0]};
        2'd1: begin
          pk[2*e]   = {flag_i[e], lane_i[e][7:0]};
          pk[2*e+1] = {flag_i[e], lane_i[e][15:8]};
        end
        default: begin
          for (int t = 0; t < 4; t++) pk[4*e+t] = {flag_i[e], lane_i[e][8*t +: 8]};
        end
      endcase
    end
  end

  always_comb begin
    logic [OW-1:0] idx;
    for (int j = 0; j < RB; j++) begin
      idx        = OW'(j) - off;
      row_o[j]   = row + ((OW'(j) < off) ? RW'(1) : RW'(0));
      wdata_o[j] = pk[idx];
      we_o[j]    = en_i && ({1'b0, idx} < nbytes);
    end
  end
endmodule

// File: rtl/vspad_align.sv
module vspad_align
  import vspad_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROWS  = 16,
  parameter int LEN_W = 8,
  localparam int RB  = NB * 4,
  localparam int OW  = $clog2(RB),
  localparam int RW  = $clog2(ROWS),
  localparam int AW  = OW + RW,
  localparam int NVW = $clog2(NB + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             op_i,
  input  logic [1:0]       src_sz_i,
  input  logic [1:0]       dst_sz_i,
  input  logic             src_signed_i,
  input  logic [AW-1:0]    ptr_a_i,
  input  logic [AW-1:0]    ptr_b_i,
  input  logic [AW-1:0]    ptr_d_i,
  input  logic [LEN_W-1:0] vlen_i,
  output logic             busy_o,
  output logic             done_o,
  input  logic             hst_we_i,
  input  logic [AW-1:0]    hst_addr_i,
  input  logic [8:0]       hst_wdata_i,
  output logic [8:0]       hst_rdata_o
);
  st_e             st_q;
  logic [LEN_W-1:0] rem_q;
  logic [AW-1:0]   ba_q, bb_q, bd_q;
  logic            op_q, sgn_q, done_q;
  logic [1:0]      ssz_q, dsz_q;
  logic [NVW-1:0]  nval;

  logic [RB-1:0][RW-1:0] arow, brow, drow;
  logic [RB-1:0][8:0]    rda, rdb, rdh, dwd;
  logic [RB-1:0]         eng_we;
  logic [NB-1:0][31:0]   la, lb, res;
  logic [NB-1:0]         fa, fb, rflag;

  assign busy_o = (st_q == ST_RUN);
  assign done_o = done_q;
  assign nval   = (rem_q > LEN_W'(NB)) ? NVW'(NB) : NVW'(rem_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; rem_q <= '0; done_q <= 1'b0;
      ba_q <= '0; bb_q <= '0; bd_q <= '0;
      op_q <= 1'b0; sgn_q <= 1'b0; ssz_q <= '0; dsz_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RUN;
          rem_q <= vlen_i;
          ba_q  <= ptr_a_i; bb_q <= ptr_b_i; bd_q <= ptr_d_i;
          op_q  <= op_i; sgn_q <= src_signed_i;
          ssz_q <= norm_sz(src_sz_i); dsz_q <= norm_sz(dst_sz_i);
        end
        default: begin
          ba_q  <= ba_q + (AW'(NB) << ssz_q);
          bb_q  <= bb_q + (AW'(NB) << ssz_q);
          bd_q  <= bd_q + (AW'(NB) << dsz_q);
          rem_q <= rem_q - LEN_W'(nval);
          if (rem_q <= LEN_W'(NB)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  vspad_src_align #(.NB(NB), .ROWS(ROWS)) u_src_a (
    .base_i(ba_q), .sz_i(ssz_q), .sgn_i(sgn_q), .row_o(arow),
    .rd_i(rda), .lane_o(la), .flag_o(fa));

  vspad_src_align #(.NB(NB), .ROWS(ROWS)) u_src_b (
    .base_i(bb_q), .sz_i(ssz_q), .sgn_i(sgn_q), .row_o(brow),
    .rd_i(rdb), .lane_o(lb), .flag_o(fb));

  // placeholder ALU: pass A or add, carry taken at the destination width
  for (genvar e = 0; e < NB; e++) begin : g_alu
    logic [32:0] sum;
    logic [5:0]  cbit;
    assign sum  = {1'b0, la[e]} + {1'b0, lb[e]};
    assign cbit = (dsz_q == 2'd0) ? 6'd8 : (dsz_q == 2'd1) ? 6'd16 : 6'd32;
    assign res[e]   = op_q ? sum[31:0] : la[e];
    assign rflag[e] = op_q ? sum[cbit] : fa[e];
  end

  logic unused_fb;
  assign unused_fb = ^fb;

  vspad_dst_align #(.NB(NB), .ROWS(ROWS)) u_dst (
    .en_i(busy_o), .base_i(bd_q), .sz_i(dsz_q), .nval_i(nval),
    .lane_i(res), .flag_i(rflag), .row_o(drow), .wdata_o(dwd), .we_o(eng_we));

  logic [RW-1:0] hrow;
  assign hrow        = hst_addr_i[AW-1:OW];
  assign hst_rdata_o = rdh[hst_addr_i[OW-1:0]];

  for (genvar j = 0; j < RB; j++) begin : g_bank
    logic          bwe;
    logic [RW-1:0] bwa;
    logic [8:0]    bwd;
    assign bwe = busy_o ? eng_we[j] : (hst_we_i && (hst_addr_i[OW-1:0] == OW'(j)));
    assign bwa = busy_o ? drow[j] : hrow;
    assign bwd = busy_o ? dwd[j] : hst_wdata_i;
    vspad_bank #(.ROWS(ROWS)) u_bank (
      .clk_i(clk_i), .we_i(bwe), .waddr_i(bwa), .wdata_i(bwd),
      .raddr_a_i(arow[j]), .rdata_a_o(rda[j]),
      .raddr_b_i(brow[j]), .rdata_b_o(rdb[j]),
      .raddr_h_i(hrow),    .rdata_h_o(rdh[j]));
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R9
  AST_IDLE_NO_ENG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (eng_we == '0)); // R7
  AST_LONG_VEC_STAYS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rem_q > LEN_W'(NB)) |=> busy_o); // R9
  AST_WE_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($countones(eng_we) <= (int'(nval) << dsz_q))); // R7
endmodule

// File: tb/vspad_align_tb_top.sv
module vspad_align_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       start = 0, op = 0, sgn = 0, hwe = 0;
  logic [1:0] ssz = 0, dsz = 0;
  logic [7:0] pa = 0, pb = 0, pd = 0, vl = 0, haddr = 0;
  logic [8:0] hwd = 0, hrd;
  logic       busy, done;

  int checks = 0, fails = 0;
  logic [8:0] ref_m [256];
  logic [31:0] seed = 32'h1234_5678;

  vspad_align dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .src_sz_i(ssz), .dst_sz_i(dsz), .src_signed_i(sgn),
    .ptr_a_i(pa), .ptr_b_i(pb), .ptr_d_i(pd), .vlen_i(vl),
    .busy_o(busy), .done_o(done),
    .hst_we_i(hwe), .hst_addr_i(haddr), .hst_wdata_i(hwd), .hst_rdata_o(hrd));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]} ^ 32'h9e37_79b9;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [8:0] d);
    @(negedge clk);
    hwe = 1; haddr = a; hwd = d;
    @(negedge clk);
    hwe = 0;
    ref_m[a] = d;
  endtask

  task automatic fill();
    for (int a = 0; a < 256; a++) begin
      seed = nxt(seed);
      hwrite(8'(a), seed[8:0]);
    end
  endtask

  task automatic compare_all(input string tag);
    int bad = 0;
    logic [8:0] fa = 0, fe = 0;
    int fadr = 0;
    for (int a = 0; a < 256; a++) begin
      haddr = 8'(a);
      #1;
      if (hrd !== ref_m[a] && bad == 0) begin fa = hrd; fe = ref_m[a]; fadr = a; end
      if (hrd !== ref_m[a]) bad++;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%0h expected=%0h (%0d bytes differ)", tag, fadr, fa, fe, bad);
    end
  endtask

  // byte-array model of one instruction
  task automatic model(input logic o, input logic [1:0] s, input logic [1:0] d, input logic sg,
                       input logic [7:0] a0, input logic [7:0] b0, input logic [7:0] d0, input int n);
    int sb = 1 << s, db = 1 << d;
    for (int e = 0; e < n; e++) begin
      logic [31:0] va = 0, vb = 0, r;
      logic fla = 0, f;
      logic [32:0] sum;
      for (int t = 0; t < sb; t++) begin
        va[8*t +: 8] = ref_m[8'(a0 + e*sb + t)][7:0];
        vb[8*t +: 8] = ref_m[8'(b0 + e*sb + t)][7:0];
        fla |= ref_m[8'(a0 + e*sb + t)][8];
      end
      if (sg && va[8*sb-1]) for (int t = 8*sb; t < 32; t++) va[t] = 1'b1;
      if (sg && vb[8*sb-1]) for (int t = 8*sb; t < 32; t++) vb[t] = 1'b1;
      sum = {1'b0, va} + {1'b0, vb};
      r = o ? sum[31:0] : va;
      f = o ? sum[8*db] : fla;
      for (int t = 0; t < db; t++) ref_m[8'(d0 + e*db + t)] = {f, r[8*t +: 8]};
    end
  endtask

  task automatic run_op(input string tag, input logic o, input logic [1:0] s, input logic [1:0] d,
                        input logic sg, input logic [7:0] a0, input logic [7:0] b0,
                        input logic [7:0] d0, input int n);
    int cyc = 0, dcyc = 0, expc;
    fill();
    @(negedge clk);
    op = o; ssz = s; dsz = d; sgn = sg; pa = a0; pb = b0; pd = d0; vl = 8'(n); start = 1;
    @(negedge clk);
    start = 0;
    while (!done && cyc < 200) begin
      if (busy) cyc++;
      @(negedge clk);
    end
    while (done) begin dcyc++; @(negedge clk); end
    expc = (n == 0) ? 1 : (n + 3) / 4;
    check({tag, " R9 busy cycles"}, 32'(cyc), 32'(expc));
    check({tag, " R9 done width"}, 32'(dcyc), 32'd1);
    model(o, s, d, sg, a0, b0, d0, n);
    compare_all({tag, " contents R6"});
  endtask

  task automatic t_reset();
    check("R10 busy after reset", 32'(busy), 32'd0);
    check("R10 done after reset", 32'(done), 32'd0);
  endtask

  task automatic t_host();
    hwrite(8'd37, 9'h1a5);
    hwrite(8'd38, 9'h05a);
    haddr = 8'd37; #1; check("R1 host readback 37", 32'(hrd), 32'h1a5);
    haddr = 8'd38; #1; check("R1 host readback 38", 32'(hrd), 32'h05a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_host();
    run_op("R3 aligned byte copy", 0, 2'd0, 2'd0, 0, 8'd0, 8'd80, 8'd160, 16);
    run_op("R2 R3 misaligned word copy", 0, 2'd2, 2'd2, 0, 8'd5, 8'd83, 8'd167, 7);
    run_op("R2 R8 misaligned half add", 1, 2'd1, 2'd1, 0, 8'd13, 8'd90, 8'd171, 9);
    run_op("R4 unsigned byte to half", 1, 2'd0, 2'd1, 0, 8'd3, 8'd97, 8'd182, 10);
    run_op("R4 signed byte to word", 1, 2'd0, 2'd2, 1, 8'd7, 8'd81, 8'd165, 9);
    run_op("R5 word to byte", 1, 2'd2, 2'd0, 0, 8'd2, 8'd85, 8'd190, 8);
    run_op("R5 signed half to byte", 0, 2'd1, 2'd0, 1, 8'd9, 8'd100, 8'd203, 11);
    run_op("R7 partial group", 1, 2'd1, 2'd1, 0, 8'd1, 8'd89, 8'd175, 5);
    run_op("R7 zero length", 1, 2'd0, 2'd0, 0, 8'd4, 8'd88, 8'd170, 0);
    run_op("R8 pass flags signed half to word", 0, 2'd1, 2'd2, 1, 8'd11, 8'd95, 8'd179, 6);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule